// File: doc/BRIEF.md
# Parallel Compare Predicate Writer

This block holds a file of one-bit predicate registers and updates it from several compare operations that issue together in one cycle. Each compare lane evaluates a relation between two 64-bit operands and, depending on its compare type, writes a pair of target predicates. The types cover a plain result/complement write, an unconditional form that also clears its targets when its guard is off, one-sided AND and OR forms that write only on one outcome, and two mixed forms that write complementary values on one outcome. A multi-term condition can therefore be reduced to a single predicate in one cycle, with no chain of dependent compares.

Each lane is guarded by a qualifying predicate read from the file. Each operand carries a deferred-exception flag. When a flagged operand reaches a lane whose guard is true, both targets are forced false. The effects of all lanes are merged by a fixed priority, and the updated file appears on the output one clock after the compares are presented.

Top module: `pcmp_pred_file`

## Requirements
- R1: After reset every predicate reads 0 except index 0, which reads 1. Index 0 stays 1 at all times and ignores writes.
- R2: Relation codes: 0 equal, 1 not-equal, 2 signed less-than (a < b), 3 unsigned less-than (a < b).
- R3: Type 0 (normal), guard true: target 1 gets the result and target 2 gets its complement.
- R4: Type 1 (unconditional): guard true behaves as type 0. Guard false writes 0 to both targets.
- R5: Type 2 (AND): a false result writes 0 to both targets. A true result leaves both unchanged.
- R6: Type 3 (OR): a true result writes 1 to both targets. A false result leaves both unchanged.
- R7: Type 4 (AND/OR-complement): a false result writes target 1 = 0 and target 2 = 1. Type 5 (OR/AND-complement): a true result writes target 1 = 1 and target 2 = 0. The other outcome leaves both unchanged.
- R8: With the guard true, a deferred-exception flag on either operand writes 0 to both targets for types 0 to 5.
- R9: With the guard false, types 0, 2, 3, 4 and 5 change nothing. Types 6 and 7 never change anything.
- R10: Merge rule per predicate. Writes from types 2 to 5 take priority over writes from types 0 and 1. Within each of these two groups, a write of 0 beats a write of 1. Guards read the file as it stood at the start of the cycle. Results are visible on the output after the next rising clock edge.
- R11: Several type-2 lanes aimed at the same target pair that was set to 1 leave the pair at 1 only if every lane's relation holds. Otherwise the pair becomes 0 in the same cycle.
- R12: A lane whose valid bit is low has no effect, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | NUM_LANES | Per-lane issue strobe |
| cmp_type | input | 3*NUM_LANES | Per-lane compare type code |
| cmp_rel | input | 2*NUM_LANES | Per-lane relation code |
| src_a | input | DATA_W*NUM_LANES | Per-lane first operand |
| src_b | input | DATA_W*NUM_LANES | Per-lane second operand |
| nat_a | input | NUM_LANES | Deferred-exception flag of first operand |
| nat_b | input | NUM_LANES | Deferred-exception flag of second operand |
| qp_idx | input | IDX_W*NUM_LANES | Per-lane qualifying predicate index |
| tgt1_idx | input | IDX_W*NUM_LANES | Per-lane first target index |
| tgt2_idx | input | IDX_W*NUM_LANES | Per-lane second target index |
| pred_file | output | 2**IDX_W | Current predicate file contents |

## Verification
The whole predicate file is visible at the output, so a wrong merge decision or a wrong lane effect shows up as a single flipped bit one cycle after the compare. The only exception is an error that lands on a predicate whose old value happens to equal the wrong write. For that reason each case presets its targets to the value opposite to the expected change. A wrong guard read does not appear in the target bits alone. It shows up when a guarded lane writes, or fails to write, targets that were preset to the opposite value. A stuck index-0 bit is visible directly on the output.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [2:0] {
        CT_NORM    = 3'd0,
        CT_UNC     = 3'd1,
        CT_AND     = 3'd2,
        CT_OR      = 3'd3,
        CT_ANDORCM = 3'd4,
        CT_ORANDCM = 3'd5
    } cmp_kind_e;

    typedef enum logic [1:0] {
        REL_EQ  = 2'd0,
        REL_NE  = 2'd1,
        REL_LT  = 2'd2,
        REL_LTU = 2'd3
    } cmp_rel_e;

    // effect one lane has on its two targets
    typedef struct packed {
        logic par;   // issued by a parallel type (2..5)
        logic clr1;
        logic set1;
        logic clr2;
        logic set2;
    } lane_eff_t;

endpackage

// File: rtl/pcw_relation.sv
module pcw_relation #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [1:0]        rel,
    output logic              hit
);
    import pcw_pkg::*;

    always_comb begin
        unique case (rel)
            REL_EQ:  hit = (opa == opb);
            REL_NE:  hit = (opa != opb);
            REL_LT:  hit = ($signed(opa) < $signed(opb));
            default: hit = (opa < opb);
        endcase
    end
endmodule

// File: rtl/pcw_lane.sv
module pcw_lane #(
    parameter int DATA_W = 64
) (
    input  logic                  valid,
    input  logic [2:0]            ctype,
    input  logic [1:0]            rel,
    input  logic [DATA_W-1:0]     opa,
    input  logic [DATA_W-1:0]     opb,
    input  logic                  na,
    input  logic                  nb,
    input  logic                  guard,
    output pcw_pkg::lane_eff_t    eff
);
    import pcw_pkg::*;

    logic hit;
    logic known;

    pcw_relation #(.DATA_W(DATA_W)) u_rel (
        .opa (opa),
        .opb (opb),
        .rel (rel),
        .hit (hit)
    );

    assign known = (ctype <= 3'd5);

    always_comb begin
        eff     = '0;
        eff.par = (ctype >= 3'd2);
        if (valid && known) begin
            if (!guard) begin
                if (ctype == CT_UNC) begin
                    eff.clr1 = 1'b1;
                    eff.clr2 = 1'b1;
                end
            end else if (na || nb) begin
                eff.clr1 = 1'b1;
                eff.clr2 = 1'b1;
            end else begin
                unique case (ctype)
                    CT_NORM, CT_UNC: begin
                        eff.set1 = hit;
                        eff.clr1 = !hit;
                        eff.set2 = !hit;
                        eff.clr2 = hit;
                    end
                    CT_AND: begin
                        eff.clr1 = !hit;
                        eff.clr2 = !hit;
                    end
                    CT_OR: begin
                        eff.set1 = hit;
                        eff.set2 = hit;
                    end
                    CT_ANDORCM: begin
                        eff.clr1 = !hit;
                        eff.set2 = !hit;
                    end
                    default: begin
                        eff.set1 = hit;
                        eff.clr2 = hit;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pcw_merge.sv
module pcw_merge #(
    parameter int NUM_LANES = 4,
    parameter int IDX_W     = 6,
    localparam int PRED_CNT = 1 << IDX_W
) (
    input  pcw_pkg::lane_eff_t       eff     [NUM_LANES],
    input  logic [IDX_W-1:0]         t1      [NUM_LANES],
    input  logic [IDX_W-1:0]         t2      [NUM_LANES],
    input  logic [PRED_CNT-1:0]      cur,
    output logic [PRED_CNT-1:0]      nxt
);
    logic [PRED_CNT-1:0] par_clr, par_set, nrm_clr, nrm_set;

    always_comb begin
        par_clr = '0;
        par_set = '0;
        nrm_clr = '0;
        nrm_set = '0;
        for (int l = 0; l < NUM_LANES; l++) begin
            if (eff[l].par) begin
                if (eff[l].clr1) par_clr[t1[l]] = 1'b1;
                if (eff[l].set1) par_set[t1[l]] = 1'b1;
                if (eff[l].clr2) par_clr[t2[l]] = 1'b1;
                if (eff[l].set2) par_set[t2[l]] = 1'b1;
            end else begin
                if (eff[l].clr1) nrm_clr[t1[l]] = 1'b1;
                if (eff[l].set1) nrm_set[t1[l]] = 1'b1;
                if (eff[l].clr2) nrm_clr[t2[l]] = 1'b1;
                if (eff[l].set2) nrm_set[t2[l]] = 1'b1;
            end
        end
    end

    for (genvar i = 0; i < PRED_CNT; i++) begin : g_bit
        always_comb begin
            if (par_clr[i])      nxt[i] = 1'b0;
            else if (par_set[i]) nxt[i] = 1'b1;
            else if (nrm_clr[i]) nxt[i] = 1'b0;
            else if (nrm_set[i]) nxt[i] = 1'b1;
            else                 nxt[i] = cur[i];
        end
    end
endmodule

// File: rtl/pcmp_pred_file.sv
module pcmp_pred_file #(
    parameter int NUM_LANES = 4,
    parameter int DATA_W    = 64,
    parameter int IDX_W     = 6,
    localparam int PRED_CNT = 1 << IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LANES-1:0]          cmp_valid,
    input  logic [3*NUM_LANES-1:0]        cmp_type,
    input  logic [2*NUM_LANES-1:0]        cmp_rel,
    input  logic [DATA_W*NUM_LANES-1:0]   src_a,
    input  logic [DATA_W*NUM_LANES-1:0]   src_b,
    input  logic [NUM_LANES-1:0]          nat_a,
    input  logic [NUM_LANES-1:0]          nat_b,
    input  logic [IDX_W*NUM_LANES-1:0]    qp_idx,
    input  logic [IDX_W*NUM_LANES-1:0]    tgt1_idx,
    input  logic [IDX_W*NUM_LANES-1:0]    tgt2_idx,
    output logic [PRED_CNT-1:0]           pred_file
);
    import pcw_pkg::*;

    typedef struct packed {
        logic [PRED_CNT-1:0] pred;
    } state_t;

    state_t st_d, st_q;

    lane_eff_t          eff_w [NUM_LANES];
    logic [IDX_W-1:0]   t1_w  [NUM_LANES];
    logic [IDX_W-1:0]   t2_w  [NUM_LANES];
    logic [PRED_CNT-1:0] merged_w;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic guard_w;
        assign guard_w = st_q.pred[qp_idx[l*IDX_W +: IDX_W]];
        assign t1_w[l] = tgt1_idx[l*IDX_W +: IDX_W];
        assign t2_w[l] = tgt2_idx[l*IDX_W +: IDX_W];

        pcw_lane #(.DATA_W(DATA_W)) u_lane (
            .valid (cmp_valid[l]),
            .ctype (cmp_type[l*3 +: 3]),
            .rel   (cmp_rel[l*2 +: 2]),
            .opa   (src_a[l*DATA_W +: DATA_W]),
            .opb   (src_b[l*DATA_W +: DATA_W]),
            .na    (nat_a[l]),
            .nb    (nat_b[l]),
            .guard (guard_w),
            .eff   (eff_w[l])
        );
    end

    pcw_merge #(.NUM_LANES(NUM_LANES), .IDX_W(IDX_W)) u_merge (
        .eff (eff_w),
        .t1  (t1_w),
        .t2  (t2_w),
        .cur (st_q.pred),
        .nxt (merged_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pred    = merged_w;
        st_d.pred[0] = 1'b1;   // index 0 is hardwired true
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pred    <= '0;
            st_q.pred[0] <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_file = st_q.pred;
endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
    parameter int NUM_LANES = 4,
    parameter int DATA_W    = 64,
    parameter int IDX_W     = 6,
    localparam int PRED_CNT = 1 << IDX_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LANES-1:0] cmp_valid,
    input logic [2:0]           l0_type,
    input logic [1:0]           l0_rel,
    input logic [DATA_W-1:0]    l0_a,
    input logic [DATA_W-1:0]    l0_b,
    input logic                 l0_na,
    input logic                 l0_nb,
    input logic [IDX_W-1:0]     l0_qp,
    input logic [IDX_W-1:0]     l0_t1,
    input logic [IDX_W-1:0]     l0_t2,
    input logic [PRED_CNT-1:0]  pred_file
);
    logic l0_on;
    logic l0_nat;
    assign l0_on  = cmp_valid[0] && pred_file[l0_qp];
    assign l0_nat = l0_na || l0_nb;

    assert_p0_true_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pred_file[0]);

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid == '0) |=> $stable(pred_file));

    assert_and_false_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_on && l0_type == 3'd2 && l0_rel == 2'd0 && !l0_nat &&
         l0_a != l0_b && l0_t1 != '0)
        |=> !pred_file[$past(l0_t1)]);

    assert_nat_forces_false_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_on && l0_type == 3'd2 && l0_nat && l0_t2 != '0)
        |=> !pred_file[$past(l0_t2)]);

    assert_guard_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid == NUM_LANES'(1) && !pred_file[l0_qp] && l0_type != 3'd1)
        |=> $stable(pred_file));

    assert_or_true_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (l0_on && cmp_valid == NUM_LANES'(1) && l0_type == 3'd3 &&
         l0_rel == 2'd0 && l0_a == l0_b && !l0_nat && l0_t1 != '0)
        |=> pred_file[$past(l0_t1)]);
endmodule

bind pcmp_pred_file pcw_checker #(
    .NUM_LANES (NUM_LANES),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_valid (cmp_valid),
    .l0_type   (cmp_type[2:0]),
    .l0_rel    (cmp_rel[1:0]),
    .l0_a      (src_a[DATA_W-1:0]),
    .l0_b      (src_b[DATA_W-1:0]),
    .l0_na     (nat_a[0]),
    .l0_nb     (nat_b[0]),
    .l0_qp     (qp_idx[IDX_W-1:0]),
    .l0_t1     (tgt1_idx[IDX_W-1:0]),
    .l0_t2     (tgt2_idx[IDX_W-1:0]),
    .pred_file (pred_file)
);

// File: tb/pcmp_pred_file_tb.sv
module pcmp_pred_file_tb;
    localparam int L  = 4;
    localparam int DW = 64;
    localparam int IW = 6;
    localparam int PC = 1 << IW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [L-1:0]    cmp_valid;
    logic [3*L-1:0]  cmp_type;
    logic [2*L-1:0]  cmp_rel;
    logic [DW*L-1:0] src_a, src_b;
    logic [L-1:0]    nat_a, nat_b;
    logic [IW*L-1:0] qp_idx, tgt1_idx, tgt2_idx;
    logic [PC-1:0]   pred_file;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pcmp_pred_file #(.NUM_LANES(L), .DATA_W(DW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_type(cmp_type),
        .cmp_rel(cmp_rel), .src_a(src_a), .src_b(src_b), .nat_a(nat_a),
        .nat_b(nat_b), .qp_idx(qp_idx), .tgt1_idx(tgt1_idx),
        .tgt2_idx(tgt2_idx), .pred_file(pred_file)
    );

    typedef struct packed {
        logic [2:0]  ct;
        logic [1:0]  rel;
        logic [63:0] a;
        logic [63:0] b;
        logic        na;
        logic        nb;
        logic [5:0]  qp;
        logic        i1;
        logic        i2;
        logic        e1;
        logic        e2;
        logic [3:0]  req;
    } vec_t;

    localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
    // targets are p10/p11; p0 and p2 are true, p1 is false
    localparam vec_t VECS [20] = '{
        '{3'd0, 2'd0, 64'd5, 64'd5, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3
        '{3'd0, 2'd0, 64'd5, 64'd6, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
        '{3'd0, 2'd1, 64'd5, 64'd6, 1'b0, 1'b0, 6'd1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
        '{3'd1, 2'd0, 64'd5, 64'd5, 1'b0, 1'b0, 6'd1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd4},  // R4
        '{3'd1, 2'd2, M1,    64'd1, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd2},  // R2
        '{3'd0, 2'd3, M1,    64'd1, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
        '{3'd2, 2'd0, 64'd3, 64'd4, 1'b0, 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},  // R5
        '{3'd2, 2'd0, 64'd3, 64'd3, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},  // R5
        '{3'd3, 2'd1, 64'd3, 64'd4, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd6},  // R6
        '{3'd3, 2'd1, 64'd3, 64'd3, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd6},  // R6
        '{3'd4, 2'd0, 64'd1, 64'd2, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7
        '{3'd4, 2'd0, 64'd2, 64'd2, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},  // R7
        '{3'd5, 2'd3, 64'd1, 64'd2, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7},  // R7
        '{3'd5, 2'd3, 64'd2, 64'd1, 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},  // R7
        '{3'd3, 2'd1, 64'd3, 64'd4, 1'b1, 1'b0, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{3'd0, 2'd0, 64'd5, 64'd5, 1'b0, 1'b1, 6'd0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd8},  // R8
        '{3'd2, 2'd0, 64'd3, 64'd4, 1'b0, 1'b0, 6'd1, 1'b1, 1'b1, 1'b1, 1'b1, 4'd9},  // R9
        '{3'd6, 2'd0, 64'd3, 64'd3, 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
        '{3'd0, 2'd2, 64'd1, M1,    1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2},  // R2
        '{3'd1, 2'd1, 64'd7, 64'd7, 1'b0, 1'b0, 6'd2, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4}   // R4
    };

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic clear_lanes();
        cmp_valid = '0; cmp_type = '0; cmp_rel = '0; src_a = '0; src_b = '0;
        nat_a = '0; nat_b = '0; qp_idx = '0; tgt1_idx = '0; tgt2_idx = '0;
    endtask

    task automatic set_lane(input int l, input logic [2:0] ct, input logic [1:0] rel,
                            input logic [63:0] a, input logic [63:0] b,
                            input logic na, input logic nb, input logic [5:0] qp,
                            input logic [5:0] t1, input logic [5:0] t2);
        cmp_valid[l]        = 1'b1;
        cmp_type[l*3 +: 3]  = ct;
        cmp_rel[l*2 +: 2]   = rel;
        src_a[l*DW +: DW]   = a;
        src_b[l*DW +: DW]   = b;
        nat_a[l]            = na;
        nat_b[l]            = nb;
        qp_idx[l*IW +: IW]  = qp;
        tgt1_idx[l*IW +: IW] = t1;
        tgt2_idx[l*IW +: IW] = t2;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        clear_lanes();
    endtask

    // write value vp to predicate p and vq to predicate q (normal compares, second target p0)
    task automatic preset(input logic [5:0] p, input logic vp, input logic [5:0] q, input logic vq);
        set_lane(0, 3'd0, 2'd0, 64'd0, {63'd0, !vp}, 1'b0, 1'b0, 6'd0, p, 6'd0);
        set_lane(1, 3'd0, 2'd0, 64'd0, {63'd0, !vq}, 1'b0, 1'b0, 6'd0, q, 6'd0);
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        logic [PC-1:0] snap;
        clear_lanes();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (pred_file !== 64'h1) begin
            fails++;
            $display("FAIL R1 reset: actual %h expected %h", pred_file, 64'h1);
        end

        preset(6'd2, 1'b1, 6'd3, 1'b0);

        for (int v = 0; v < 20; v++) begin
            preset(6'd10, VECS[v].i1, 6'd11, VECS[v].i2);
            set_lane(0, VECS[v].ct, VECS[v].rel, VECS[v].a, VECS[v].b,
                     VECS[v].na, VECS[v].nb, VECS[v].qp, 6'd10, 6'd11);
            step();
            chk(pred_file[10], VECS[v].e1, $sformatf("R%0d vec%0d t1", VECS[v].req, v));
            chk(pred_file[11], VECS[v].e2, $sformatf("R%0d vec%0d t2", VECS[v].req, v));
        end

        // R1: writes aimed at index 0 are discarded
        set_lane(0, 3'd0, 2'd0, 64'd5, 64'd6, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0);
        set_lane(1, 3'd2, 2'd0, 64'd5, 64'd6, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0);
        step();
        chk(pred_file[0], 1'b1, "R1 write to p0");

        // R11: four AND lanes, all relations hold -> pair stays 1
        preset(6'd20, 1'b1, 6'd21, 1'b1);
        for (int l = 0; l < L; l++)
            set_lane(l, 3'd2, 2'd0, 64'(l), 64'(l), 1'b0, 1'b0, 6'd0, 6'd20, 6'd21);
        step();
        chk(pred_file[20], 1'b1, "R11 all-true t1");
        chk(pred_file[21], 1'b1, "R11 all-true t2");
        // R11: one term fails -> pair 0
        for (int l = 0; l < L; l++)
            set_lane(l, 3'd2, 2'd0, 64'(l), (l == 2) ? 64'd9 : 64'(l), 1'b0, 1'b0, 6'd0, 6'd20, 6'd21);
        step();
        chk(pred_file[20], 1'b0, "R11 one-false t1");
        chk(pred_file[21], 1'b0, "R11 one-false t2");

        // R10: parallel OR set beats normal clear on p31
        preset(6'd30, 1'b0, 6'd31, 1'b1);
        set_lane(0, 3'd0, 2'd0, 64'd1, 64'd1, 1'b0, 1'b0, 6'd0, 6'd30, 6'd31);
        set_lane(1, 3'd3, 2'd1, 64'd1, 64'd2, 1'b0, 1'b0, 6'd0, 6'd31, 6'd0);
        step();
        chk(pred_file[30], 1'b1, "R10 normal write p30");
        chk(pred_file[31], 1'b1, "R10 parallel over normal p31");

        // R10: parallel AND clear beats parallel OR set on p32
        preset(6'd32, 1'b0, 6'd33, 1'b0);
        set_lane(0, 3'd3, 2'd0, 64'd1, 64'd1, 1'b0, 1'b0, 6'd0, 6'd32, 6'd0);
        set_lane(1, 3'd2, 2'd0, 64'd1, 64'd2, 1'b0, 1'b0, 6'd0, 6'd32, 6'd0);
        step();
        chk(pred_file[32], 1'b0, "R10 clear over set p32");

        // R10: guard reads start-of-cycle value (p33 is 0 while being set)
        preset(6'd34, 1'b1, 6'd35, 1'b1);
        set_lane(0, 3'd0, 2'd0, 64'd1, 64'd1, 1'b0, 1'b0, 6'd0, 6'd33, 6'd0);
        set_lane(1, 3'd1, 2'd0, 64'd1, 64'd1, 1'b0, 1'b0, 6'd33, 6'd34, 6'd35);
        step();
        chk(pred_file[33], 1'b1, "R10 guard source written");
        chk(pred_file[34], 1'b0, "R10 old guard t1");
        chk(pred_file[35], 1'b0, "R10 old guard t2");

        // R12: lanes loaded but not valid
        snap = pred_file;
        for (int l = 0; l < L; l++)
            set_lane(l, 3'd1, 2'd0, 64'd1, 64'd2, 1'b1, 1'b0, 6'd1, 6'd34 + 6'(l), 6'd2);
        cmp_valid = '0;
        step();
        checks++;
        if (pred_file !== snap) begin
            fails++;
            $display("FAIL R12 invalid lanes: actual %h expected %h", pred_file, snap);
        end

        summary();
        $finish;
    end
endmodule